// File: doc/BRIEF.md
# Read-Only NAND-Style Page Store (Device Side)

This block models the device end of a byte-wide, NAND-style read-only memory. It samples its strobes and the input byte with the system clock. Command cycles are latched on a rising write strobe while the command latch is high, and address cycles on a rising write strobe while the address latch is high. Three read commands choose where in a 528-byte page reading begins: the low main half, the high main half, or the 16-byte spare tail. A reset command aborts any operation. Page contents come from a fixed hash of page and column, so no memory image is needed.

After three address cycles the block goes busy for a modelled array access. It then hands out one byte per falling read strobe and advances the column on each rising read strobe. At the end of a page it waits for a short ready window and then goes busy again before it moves on to the next page of the same 32-page block. It stops after the last page of that block. Raising chip select inside the window ends the read with no busy period. All timings are counted in clock cycles through the `ACCESS_CYC`, `RESET_CYC` and `GAP_CYC` parameters.

Top module: `nrom_dev`

## Requirements
- R1: After reset, `ready` is 1, `dq_oe` is 0 and `proto_err` is 0.
- R2: Command 0x00, followed by address bytes C, P0 and P1, starts at column C of page {P1,P0}. A main byte (column below 512) equals col[7:0] ^ page[7:0] ^ page[15:8] ^ (col[8] ? 0xA5 : 0x00). Reading runs through column 255 into 256.
- R3: Command 0x01 starts at column 256 + C. The command supplies column bit 8; no address byte does.
- R4: Command 0x50 starts at column 512 + C[3:0], and C[7:4] is ignored. Every spare byte (columns 512 to 527) reads 0xFF. In this mode the next page resumes at column 512.
- R5: The first address byte is the column and is applied according to the command. The second is page bits 7..0 and the third is page bits 15..8.
- R6: `ready` falls at the second rising clock edge after `wr_n` rises on the third address cycle. It stays low for exactly ACCESS_CYC+1 cycles and is never low for more than ACCESS_CYC+RESET_CYC+2 cycles in a row.
- R7: After a rising read strobe on column 527, the block stays ready for GAP_CYC+1 cycles and is then busy for ACCESS_CYC+1 cycles. It then continues at column 0 of the next page after command 0x00 or 0x01.
- R8: When column 527 of a page whose low five page bits are all ones has been read, streaming stops with no busy period. Further read strobes drive nothing.
- R9: Command 0xFF is accepted even while busy without raising `proto_err`. It returns `ready` within RESET_CYC+1 cycles, and the aborted read outputs nothing afterwards.
- R10: `dq_oe` is 1 only in a data phase while chip select and the read strobe are both low. A read strobe with chip select high neither drives the bus nor advances the column.
- R11: Raising chip select during the ready window after column 527 ends the read. No busy period follows and later read strobes drive nothing.
- R12: An unknown command code, an address cycle with no read command pending, or a read strobe (with chip select low) outside a data phase is ignored and sets the sticky `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| cmd_latch | input | 1 | High marks a write cycle as a command |
| addr_latch | input | 1 | High marks a write cycle as an address byte |
| wr_n | input | 1 | Write strobe; its rising edge latches `dq_in` |
| rd_n | input | 1 | Read strobe; falling edge presents a byte, rising edge advances |
| dq_in | input | 8 | Command or address byte from the host |
| dq_out | output | 8 | Byte being read |
| dq_oe | output | 1 | Tri-state enable for `dq_out` |
| ready | output | 1 | 1 = ready, 0 = busy |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Every strobe edge is registered once and acted on at the next rising edge. A write or read strobe edge therefore affects `ready`, `dq_oe`, `dq_out` and `proto_err` at the second rising clock edge after the edge. The bench changes inputs at falling edges and reads results two or three falling edges after the strobe edge, which is past that second rising edge. Busy periods are measured by counting falling edges with `ready` low, from the first falling edge after the busy state is entered. An access therefore counts exactly ACCESS_CYC+1, and a reset counts at most RESET_CYC+1. The checks for "stays ready" and "drives nothing" watch the ports across a window longer than the gap and the access together.

// File: rtl/nrom_pkg.sv
package nrom_pkg;

    localparam int COL_W     = 10;
    localparam int PAGE_W    = 16;
    localparam int SPARE_OFS = 512;
    localparam int LAST_COL  = 527;

    localparam logic [7:0] OP_READ_LO = 8'h00;
    localparam logic [7:0] OP_READ_HI = 8'h01;
    localparam logic [7:0] OP_READ_SP = 8'h50;
    localparam logic [7:0] OP_RESET   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_DATA,
        ST_GAP,
        ST_RESET
    } state_e;

    typedef enum logic [1:0] {
        AREA_LO,
        AREA_HI,
        AREA_SP
    } area_e;

    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic [7:0] io;
    } pins_t;

endpackage

// File: rtl/nrom_pin_sampler.sv
module nrom_pin_sampler
    import nrom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output pins_t pins_o,
    output logic  we_rise_o,
    output logic  re_fall_o,
    output logic  re_rise_o
);

    typedef struct packed {
        pins_t cur;
        logic  we_prev;
        logic  re_prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.cur     = pins_i;
        s_d.we_prev = s_q.cur.we_n;
        s_d.re_prev = s_q.cur.re_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cur.ce_n <= 1'b1;
            s_q.cur.cle  <= 1'b0;
            s_q.cur.ale  <= 1'b0;
            s_q.cur.we_n <= 1'b1;
            s_q.cur.re_n <= 1'b1;
            s_q.cur.io   <= '0;
            s_q.we_prev  <= 1'b1;
            s_q.re_prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pins_o    = s_q.cur;
    assign we_rise_o = s_q.cur.we_n & ~s_q.we_prev;
    assign re_fall_o = ~s_q.cur.re_n & s_q.re_prev;
    assign re_rise_o = s_q.cur.re_n & ~s_q.re_prev;

endmodule

// File: rtl/nrom_wait_timer.sv
module nrom_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/nrom_cell_src.sv
module nrom_cell_src
    import nrom_pkg::*;
(
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [7:0]        byte_o
);

    logic [7:0] half_mix;

    always_comb begin
        half_mix = col_i[8] ? 8'hA5 : 8'h00;
        if (col_i >= COL_W'(SPARE_OFS)) begin
            byte_o = 8'hFF;
        end else begin
            byte_o = col_i[7:0] ^ page_i[7:0] ^ page_i[15:8] ^ half_mix;
        end
    end

endmodule

// File: rtl/nrom_dev.sv
module nrom_dev
    import nrom_pkg::*;
#(
    parameter int ACCESS_CYC  = 40,
    parameter int RESET_CYC   = 12,
    parameter int GAP_CYC     = 6,
    parameter int BLOCK_PAGES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_sel_n,
    input  logic       cmd_latch,
    input  logic       addr_latch,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic [7:0] dq_in,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       ready,
    output logic       proto_err
);

    localparam int MAX_AR  = (ACCESS_CYC > RESET_CYC) ? ACCESS_CYC : RESET_CYC;
    localparam int TMR_MAX = (MAX_AR > GAP_CYC) ? MAX_AR : GAP_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int BLK_W   = $clog2(BLOCK_PAGES);

    typedef struct packed {
        state_e             st;
        area_e              area;
        logic [1:0]         acnt;
        logic [COL_W-1:0]   col;
        logic [PAGE_W-1:0]  page;
        logic [7:0]         dout;
        logic               oe;
        logic               err;
    } core_t;

    core_t r_d, r_q;

    pins_t             pins_raw, smp;
    logic              we_rise, rd_fall, rd_rise;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic [7:0]        cell_byte;
    logic              cmd_stb, adr_stb, busy_now, blk_last;
    area_e             area_mon;
    logic [COL_W-1:0]  col_mon;

    assign pins_raw.ce_n = chip_sel_n;
    assign pins_raw.cle  = cmd_latch;
    assign pins_raw.ale  = addr_latch;
    assign pins_raw.we_n = wr_n;
    assign pins_raw.re_n = rd_n;
    assign pins_raw.io   = dq_in;

    nrom_pin_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_raw),
        .pins_o    (smp),
        .we_rise_o (we_rise),
        .re_fall_o (rd_fall),
        .re_rise_o (rd_rise)
    );

    nrom_wait_timer #(.W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    nrom_cell_src u_cell (
        .page_i (r_q.page),
        .col_i  (r_q.col),
        .byte_o (cell_byte)
    );

    assign cmd_stb  = we_rise & ~smp.ce_n & smp.cle & ~smp.ale;
    assign adr_stb  = we_rise & ~smp.ce_n & smp.ale & ~smp.cle;
    assign busy_now = (r_q.st == ST_ACCESS) || (r_q.st == ST_RESET);
    assign blk_last = (r_q.page[BLK_W-1:0] == {BLK_W{1'b1}});

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (cmd_stb && smp.io == OP_RESET) begin
            r_d.st   = ST_RESET;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(RESET_CYC);
        end else if (cmd_stb) begin
            if (busy_now) begin
                r_d.err = 1'b1;
            end else begin
                case (smp.io)
                    OP_READ_LO: begin r_d.area = AREA_LO; r_d.st = ST_ADDR; r_d.acnt = 2'd0; end
                    OP_READ_HI: begin r_d.area = AREA_HI; r_d.st = ST_ADDR; r_d.acnt = 2'd0; end
                    OP_READ_SP: begin r_d.area = AREA_SP; r_d.st = ST_ADDR; r_d.acnt = 2'd0; end
                    default:    r_d.err = 1'b1;
                endcase
            end
        end else if (adr_stb) begin
            if (r_q.st != ST_ADDR) begin
                r_d.err = 1'b1;
            end else begin
                case (r_q.acnt)
                    2'd0: begin
                        case (r_q.area)
                            AREA_LO: r_d.col = {2'b00, smp.io};
                            AREA_HI: r_d.col = {2'b01, smp.io};
                            default: r_d.col = {6'b100000, smp.io[3:0]};
                        endcase
                        r_d.acnt = 2'd1;
                    end
                    2'd1: begin
                        r_d.page[7:0] = smp.io;
                        r_d.acnt      = 2'd2;
                    end
                    default: begin
                        r_d.page[15:8] = smp.io;
                        r_d.acnt       = 2'd0;
                        r_d.st         = ST_ACCESS;
                        tmr_load       = 1'b1;
                        tmr_val        = TMR_W'(ACCESS_CYC);
                    end
                endcase
            end
        end else begin
            case (r_q.st)
                ST_ACCESS: if (tmr_done) r_d.st = ST_DATA;
                ST_RESET:  if (tmr_done) r_d.st = ST_IDLE;
                ST_GAP: begin
                    if (smp.ce_n) begin
                        r_d.st = ST_IDLE;
                    end else if (tmr_done) begin
                        r_d.st   = ST_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(ACCESS_CYC);
                    end
                end
                ST_DATA: begin
                    if (rd_fall && !smp.ce_n) begin
                        r_d.dout = cell_byte;
                    end else if (rd_rise && !smp.ce_n) begin
                        if (r_q.col == COL_W'(LAST_COL)) begin
                            if (blk_last) begin
                                r_d.st = ST_IDLE;
                            end else begin
                                r_d.st   = ST_GAP;
                                r_d.page = r_q.page + 1'b1;
                                r_d.col  = (r_q.area == AREA_SP) ? COL_W'(SPARE_OFS) : '0;
                                tmr_load = 1'b1;
                                tmr_val  = TMR_W'(GAP_CYC);
                            end
                        end else begin
                            r_d.col = r_q.col + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (rd_fall && !smp.ce_n && r_q.st != ST_DATA) begin
            r_d.err = 1'b1;
        end
        r_d.oe = (r_d.st == ST_DATA) && !smp.ce_n && !smp.re_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.area <= AREA_LO;
            r_q.acnt <= '0;
            r_q.col  <= '0;
            r_q.page <= '0;
            r_q.dout <= '0;
            r_q.oe   <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dq_out    = r_q.dout;
    assign dq_oe     = r_q.oe;
    assign ready     = ~busy_now;
    assign proto_err = r_q.err;
    assign area_mon  = r_q.area;
    assign col_mon   = r_q.col;

endmodule

// File: rtl/nrom_chk.sv
module nrom_chk
    import nrom_pkg::*;
#(
    parameter int ACCESS_CYC = 40,
    parameter int RESET_CYC  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_sel_n,
    input logic             rd_n,
    input logic             ready,
    input logic             dq_oe,
    input logic [7:0]       dq_out,
    input logic             proto_err,
    input area_e            area_mon,
    input logic [COL_W-1:0] col_mon
);

    localparam int LOW_LIMIT = ACCESS_CYC + RESET_CYC + 2;

    logic [15:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  low_run_q <= '0;
        else if (ready)              low_run_q <= '0;
        else if (low_run_q != '1)    low_run_q <= low_run_q + 16'd1;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            AST_BUSY_BOUNDED: assert (int'(low_run_q) <= LOW_LIMIT) else $error("busy run too long"); // R6
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (ready && !dq_oe && !proto_err)); // R1

    AST_OE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> ready); // R10

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!$past(rd_n, 2) && !$past(chip_sel_n, 2))); // R10

    AST_SPARE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && area_mon == AREA_SP) |-> (dq_out == 8'hFF)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err); // R12

    AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n) col_mon <= COL_W'(LAST_COL)); // R7

endmodule

bind nrom_dev nrom_chk #(.ACCESS_CYC(ACCESS_CYC), .RESET_CYC(RESET_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .rd_n       (rd_n),
    .ready      (ready),
    .dq_oe      (dq_oe),
    .dq_out     (dq_out),
    .proto_err  (proto_err),
    .area_mon   (area_mon),
    .col_mon    (col_mon)
);

// File: tb/sim_nrom_dev.sv
module sim_nrom_dev;

    localparam int CLK_PERIOD = 10;
    localparam int ACC   = 40;
    localparam int RST_C = 12;
    localparam int GAP   = 6;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] c0;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [3:0] nrd;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 4'd4},
        '{8'h00, 8'hFF, 8'h34, 8'h12, 4'd3},
        '{8'h01, 8'h00, 8'h35, 8'h12, 4'd3},
        '{8'h01, 8'h7C, 8'hA0, 8'hFE, 4'd3},
        '{8'h50, 8'hF3, 8'h01, 8'h00, 4'd3},
        '{8'h50, 8'h00, 8'hFF, 8'hFF, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel_n = 1'b1;
    logic       cmd_latch = 1'b0;
    logic       addr_latch = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] dq_in = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe, ready, proto_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nrom_dev #(.ACCESS_CYC(ACC), .RESET_CYC(RST_C), .GAP_CYC(GAP), .BLOCK_PAGES(32)) u0 (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .wr_n(wr_n), .rd_n(rd_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .ready(ready), .proto_err(proto_err)
    );

    function automatic logic [7:0] model_byte(input logic [15:0] pg, input int col);
        logic [9:0] c;
        c = col[9:0];
        if (col >= 512) return 8'hFF;
        return c[7:0] ^ pg[7:0] ^ pg[15:8] ^ (c[8] ? 8'hA5 : 8'h00);
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_cmd(input logic [7:0] v);
        chip_sel_n = 1'b0; cmd_latch = 1'b1; addr_latch = 1'b0; dq_in = v; wr_n = 1'b0;
        cyc(2); wr_n = 1'b1; cyc(2); cmd_latch = 1'b0;
    endtask

    task automatic put_addr(input logic [7:0] v);
        chip_sel_n = 1'b0; addr_latch = 1'b1; cmd_latch = 1'b0; dq_in = v; wr_n = 1'b0;
        cyc(2); wr_n = 1'b1; cyc(2); addr_latch = 1'b0;
    endtask

    task automatic start_read(input logic [7:0] op, input logic [7:0] c0, input logic [7:0] p0, input logic [7:0] p1);
        put_cmd(op); put_addr(c0); put_addr(p0); put_addr(p1);
    endtask

    task automatic rd_byte(output logic oe, output logic [7:0] d);
        rd_n = 1'b0; cyc(3); oe = dq_oe; d = dq_out; rd_n = 1'b1; cyc(3);
    endtask

    task automatic wait_ready(input string tag, input int limit, output int low);
        low = 0;
        while (!ready && low < limit + 20) begin low++; cyc(1); end
        check(ready && low <= limit, tag, "busy length", low, limit);
    endtask

    task automatic wait_drop(input string tag);
        int t;
        t = 0;
        while (ready && t < GAP + 10) begin t++; cyc(1); end
        check(!ready, tag, "busy between pages", ready, 0);
    endtask

    task automatic hold_ready(input string tag);
        int lows;
        lows = 0;
        for (int i = 0; i < ACC + GAP + 10; i++) begin
            if (!ready) lows++;
            cyc(1);
        end
        check(lows == 0, tag, "cycles busy after read end", lows, 0);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0; chip_sel_n = 1'b1; cmd_latch = 1'b0; addr_latch = 1'b0;
        wr_n = 1'b1; rd_n = 1'b1; dq_in = 8'h00;
        cyc(3); rst_n = 1'b1; cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic       oe;
        logic [7:0] d;
        int         low, col;
        logic [15:0] pg;
        string      tag;

        hw_reset();
        // R1: reset state
        check(ready == 1'b1, "R1", "ready after reset", ready, 1);
        check(dq_oe == 1'b0, "R1", "bus enable after reset", dq_oe, 0);
        check(proto_err == 1'b0, "R1", "error after reset", proto_err, 0);

        // vector table: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < 6; v++) begin
            start_read(VECS[v].op, VECS[v].c0, VECS[v].p0, VECS[v].p1);
            check(!ready, "R6", "busy after third address", ready, 0);
            wait_ready("R6", ACC + 1, low);
            if (v == 0) check(low == ACC + 1, "R6", "exact busy length", low, ACC + 1);
            pg = {VECS[v].p1, VECS[v].p0};
            if (VECS[v].op == 8'h01)      begin col = 256 + int'(VECS[v].c0); tag = "R3/R5"; end
            else if (VECS[v].op == 8'h50) begin col = 512 + int'(VECS[v].c0[3:0]); tag = "R4/R5"; end
            else                          begin col = int'(VECS[v].c0); tag = "R2/R5"; end
            for (int k = 0; k < int'(VECS[v].nrd); k++) begin
                rd_byte(oe, d);
                check(oe == 1'b1, "R10", "bus enable during read", oe, 1);
                check(d == model_byte(pg, col + k), tag, "data byte", d, model_byte(pg, col + k));
            end
            check(dq_oe == 1'b0, "R10", "bus released with read strobe high", dq_oe, 0);
        end

        // R10: read strobe with chip select high is ignored
        start_read(8'h00, 8'h10, 8'h05, 8'h00);
        wait_ready("R6", ACC + 1, low);
        chip_sel_n = 1'b1;
        rd_byte(oe, d);
        check(oe == 1'b0, "R10", "bus enable with chip select high", oe, 0);
        chip_sel_n = 1'b0;
        rd_byte(oe, d);
        check(oe == 1'b1 && d == model_byte(16'h0005, 16'h10), "R10", "column not advanced", d, model_byte(16'h0005, 16'h10));

        // R7: page crossing in the main area
        start_read(8'h01, 8'd250, 8'h40, 8'h00);
        wait_ready("R6", ACC + 1, low);
        for (int k = 0; k < 22; k++) begin
            rd_byte(oe, d);
            check(oe && d == model_byte(16'h0040, 506 + k), "R7", "byte before page end", d, model_byte(16'h0040, 506 + k));
        end
        wait_drop("R7");
        wait_ready("R7", ACC + 1, low);
        for (int k = 0; k < 2; k++) begin
            rd_byte(oe, d);
            check(oe && d == model_byte(16'h0041, k), "R7", "next page column", d, model_byte(16'h0041, k));
        end

        // R4: spare area wraps to column 512 of next page
        start_read(8'h50, 8'h0E, 8'h00, 8'h01);
        wait_ready("R6", ACC + 1, low);
        for (int k = 0; k < 2; k++) begin
            rd_byte(oe, d);
            check(oe && d == 8'hFF, "R4", "spare byte", d, 8'hFF);
        end
        wait_drop("R4");
        wait_ready("R4", ACC + 1, low);
        rd_byte(oe, d);
        check(oe && d == 8'hFF, "R4", "wrapped spare byte", d, 8'hFF);

        // R8: end of block stops streaming
        start_read(8'h01, 8'hFF, 8'h1F, 8'h00);
        wait_ready("R6", ACC + 1, low);
        for (int k = 0; k < 17; k++) begin
            rd_byte(oe, d);
            check(oe && d == model_byte(16'h001F, 511 + k), "R8", "last page byte", d, model_byte(16'h001F, 511 + k));
        end
        hold_ready("R8");
        rd_byte(oe, d);
        check(oe == 1'b0, "R8", "bus enable after block end", oe, 0);

        // R11: chip select high in the ready window ends the read
        hw_reset();
        start_read(8'h01, 8'hFF, 8'h02, 8'h00);
        wait_ready("R6", ACC + 1, low);
        for (int k = 0; k < 17; k++) rd_byte(oe, d);
        chip_sel_n = 1'b1;
        hold_ready("R11");
        chip_sel_n = 1'b0;
        rd_byte(oe, d);
        check(oe == 1'b0, "R11", "bus enable after abort", oe, 0);

        // R12: unknown command
        hw_reset();
        put_cmd(8'h90);
        check(proto_err == 1'b1 && ready == 1'b1, "R12", "error on unknown command", proto_err, 1);
        // R12: read strobe outside data phase
        hw_reset();
        chip_sel_n = 1'b0;
        rd_byte(oe, d);
        check(oe == 1'b0, "R12", "bus enable outside data phase", oe, 0);
        check(proto_err == 1'b1, "R12", "error on stray read strobe", proto_err, 1);
        // R12: address with no command
        hw_reset();
        put_addr(8'h12);
        check(proto_err == 1'b1 && ready == 1'b1, "R12", "error on stray address", proto_err, 1);

        // R9: reset command while busy
        hw_reset();
        start_read(8'h00, 8'h00, 8'h07, 8'h00);
        check(!ready, "R9", "busy before reset command", ready, 0);
        cyc(5);
        put_cmd(8'hFF);
        check(!ready, "R9", "busy during reset", ready, 0);
        wait_ready("R9", RST_C + 1, low);
        check(proto_err == 1'b0, "R9", "no error from reset while busy", proto_err, 0);
        rd_byte(oe, d);
        check(oe == 1'b0, "R9", "bus enable after reset abort", oe, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule